// File: doc/BRIEF.md
# Sync Character Hunt Receiver

This block is the serial front end of a byte-oriented synchronous receiver. Each cycle in which the bit strobe is high, one serial bit is taken in. After reset or an enter-hunt command, the receiver is in hunt. In hunt it slides each new bit into a shift register and compares the most recent bits with a programmable sync pattern of 6, 8, 12 or 16 bits. When the pattern is found, it drops hunt, groups the bits that follow into characters and writes each finished character into a four-entry receive FIFO.

Two control bits select the pattern length. The sync pattern register is up to 16 bits wide, and only its low bits for the selected length are used. A status output shows whether the receiver is hunting or in sync. A sticky flag records any character lost to a full FIFO. Software or a dropout detector issues the enter-hunt command whenever the receiver must resynchronise.

The controller has two states:
- `ST_HUNT` is entered on reset and on the enter-hunt command from either state.
- `ST_SYNC` is entered from `ST_HUNT` on the strobe whose bit completes a match.
- `ST_SYNC` is left only by the enter-hunt command.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `hunting` is 1, `rd_valid` is 0 and `overrun` is 0.
- R2: The sync length N comes from {`len_a`,`len_b`}: 2'b11 gives 6 bits, 2'b10 gives 8 bits, 2'b01 gives 12 bits and 2'b00 gives 16 bits.
- R3: The newest received bit sits at bit 0 of the shift register. Only its low N bits are compared with `sync_pat[N-1:0]`, so the pattern is sent from bit N-1 down to bit 0. Bits of `sync_pat` at or above N have no effect.
- R4: A match can only be declared once at least N bits have been shifted since hunt was entered. It is declared on the strobe whose bit completes the pattern, and `hunting` is 0 from the next cycle. The comparison slides one bit at a time, so leading bits that are not part of the pattern are skipped.
- R5: In sync, the first bit after the match starts a new character of CHAR_W bits (default 8). The first received bit becomes the MSB. The character is written on the strobe that carries its last bit, and no character is written while hunting.
- R6: Cycles with `rx_en` low shift nothing and do not change the state, whatever `rx_bit` does.
- R7: The FIFO holds 4 characters in arrival order. `rd_valid` is high while it is not empty, and `rd_data` then shows the oldest entry. Holding `rd_en` high for one cycle removes that entry.
- R8: A character finished while the FIFO is full is dropped and sets `overrun`. `overrun` then stays at 1 until reset.
- R9: `hunt_cmd` returns the receiver to hunt in the next cycle. It discards any partial character and restarts the count of shifted bits. Bits already in the shift register cannot complete a match before N new bits have arrived. FIFO contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial data bit |
| rx_en | input | 1 | Bit strobe; one bit taken per cycle when high |
| sync_pat | input | 16 | Sync pattern; low N bits used |
| len_a | input | 1 | Length select, upper bit |
| len_b | input | 1 | Length select, lower bit |
| hunt_cmd | input | 1 | Enter hunt (one-cycle pulse) |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| rd_data | output | 8 | Oldest FIFO character |
| rd_valid | output | 1 | FIFO not empty |
| hunting | output | 1 | 1 while hunting, 0 when in sync |
| overrun | output | 1 | Sticky: a character was lost to a full FIFO |

## Verification
Each of the four length codes is tried with a pattern that has nonzero bits above N. Sync must fall on exactly the Nth bit, and not one bit earlier, which separates a correct length decode and mask from a shifted or unmasked compare.

A pattern preceded by stray bits shows that the hunt slides one bit at a time. A resynchronisation leaves stale shift contents that would match after seven bits. This separates a restarted bit count from a compare that trusts old register contents.

Toggling data with the strobe low, a partial character cut off by the hunt command, and five characters written into four FIFO slots cover the remaining strobe, discard and drop rules.

// File: rtl/shr_pkg.sv
package shr_pkg;
    localparam int SYNC_MAX = 16;
    localparam int LEN_W    = $clog2(SYNC_MAX + 2);

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_SYNC = 1'b1
    } rx_state_e;

    // {a,b}: 11 -> 6, 10 -> 8, 01 -> 12, 00 -> 16
    function automatic logic [LEN_W-1:0] sync_len(input logic a, input logic b);
        unique case ({a, b})
            2'b11:   return LEN_W'(6);
            2'b10:   return LEN_W'(8);
            2'b01:   return LEN_W'(12);
            default: return LEN_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/shr_hunt_shift.sv
module shr_hunt_shift
    import shr_pkg::*;
#(
    parameter int PAT_W = SYNC_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             clear,
    input  logic             bit_in,
    input  logic [PAT_W-1:0] pat,
    input  logic [LEN_W-1:0] len,
    output logic             match
);
    logic [PAT_W-1:0] sr_q, sr_nx, mask;
    logic [LEN_W-1:0] fill_q;

    assign sr_nx = {sr_q[PAT_W-2:0], bit_in};

    // Bit i takes part in the compare only below the selected length.
    for (genvar i = 0; i < PAT_W; i++) begin : g_mask
        assign mask[i] = (len > LEN_W'(i));
    end

    assign match = shift_en && ((fill_q + LEN_W'(1)) >= len)
                   && (((sr_nx ^ pat) & mask) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (clear) begin
            fill_q <= '0;
        end else if (shift_en) begin
            sr_q <= sr_nx;
            if (fill_q < LEN_W'(PAT_W)) fill_q <= fill_q + LEN_W'(1);
        end
    end
endmodule

// File: rtl/shr_char_asm.sv
module shr_char_asm #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              clear,
    input  logic              bit_in,
    output logic              push,
    output logic [CHAR_W-1:0] push_data
);
    localparam int CNT_W = $clog2(CHAR_W);

    logic [CHAR_W-2:0] chr_q;
    logic [CNT_W-1:0]  cnt_q;

    assign push      = bit_en && (cnt_q == CNT_W'(CHAR_W - 1));
    assign push_data = {chr_q, bit_in};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            chr_q <= '0;
        end else if (bit_en) begin
            chr_q <= push_data[CHAR_W-2:0];
            cnt_q <= push ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/shr_fifo.sv
module shr_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             not_empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_wr, do_rd;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign not_empty = (cnt_q != '0);
    assign head      = mem[rd_q];
    assign do_wr     = push && !full;
    assign do_rd     = pop && not_empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wr_q <= bump(wr_q);
            if (do_rd) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
    import shr_pkg::*;
#(
    parameter int PAT_W  = SYNC_MAX,
    parameter int CHAR_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_en,
    input  logic [PAT_W-1:0]  sync_pat,
    input  logic              len_a,
    input  logic              len_b,
    input  logic              hunt_cmd,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              hunting,
    output logic              overrun
);
    rx_state_e         state_q, state_d;
    logic              match, shift_en, asm_en;
    logic              push;
    logic [CHAR_W-1:0] push_data;
    logic              fifo_full;

    // Next-state process
    always_comb begin
        state_d = state_q;
        if (hunt_cmd) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT: if (match) state_d = ST_SYNC;
                ST_SYNC: state_d = ST_SYNC;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Outputs and datapath enables
    always_comb begin
        hunting  = (state_q == ST_HUNT);
        shift_en = rx_en && !hunt_cmd && (state_q == ST_HUNT);
        asm_en   = rx_en && !hunt_cmd && (state_q == ST_SYNC);
    end

    shr_hunt_shift #(.PAT_W(PAT_W)) u_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .clear    (hunt_cmd),
        .bit_in   (rx_bit),
        .pat      (sync_pat),
        .len      (sync_len(len_a, len_b)),
        .match    (match)
    );

    shr_char_asm #(.CHAR_W(CHAR_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (asm_en),
        .clear     (hunt_cmd),
        .bit_in    (rx_bit),
        .push      (push),
        .push_data (push_data)
    );

    shr_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (rd_en),
        .head      (rd_data),
        .not_empty (rd_valid),
        .full      (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                overrun <= 1'b0;
        else if (push && fifo_full) overrun <= 1'b1;
    end
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic hunt_cmd,
    input logic rd_valid,
    input logic hunting,
    input logic overrun
);
    AST_HUNT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> hunting);                                   // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);                                    // R8
    AST_OVR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !overrun && !rd_valid |=> !overrun);                     // R8
    AST_NO_CHAR_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        hunting && !rd_valid |=> !rd_valid);                     // R5
    AST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en && !hunt_cmd |=> $stable(hunting));               // R6
    AST_IDLE_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en && !rd_valid |=> !rd_valid);                      // R6
endmodule

bind sync_hunt_rx sync_hunt_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .hunt_cmd (hunt_cmd),
    .rd_valid (rd_valid),
    .hunting  (hunting),
    .overrun  (overrun)
);

// File: tb/sync_hunt_rx_tb_top.sv
module sync_hunt_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b0, rx_en = 1'b0;
    logic [15:0] sync_pat = '0;
    logic        len_a = 1'b0, len_b = 1'b0;
    logic        hunt_cmd = 1'b0, rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid, hunting, overrun;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    sync_hunt_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en),
        .sync_pat(sync_pat), .len_a(len_a), .len_b(len_b),
        .hunt_cmd(hunt_cmd), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .hunting(hunting), .overrun(overrun)
    );

    // {expected N[4:0], len_a, len_b, sync_pat[15:0], data[7:0]}
    localparam logic [30:0] VEC [4] = '{
        {5'd6,  1'b1, 1'b1, 16'hC02D, 8'hA5},
        {5'd8,  1'b1, 1'b0, 16'hAB16, 8'h3C},
        {5'd12, 1'b0, 1'b1, 16'hFB72, 8'h81},
        {5'd16, 1'b0, 1'b0, 16'hE4C9, 8'h5E}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk); rx_bit = b; rx_en = 1'b1;
        @(negedge clk); rx_en = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
    endtask

    task automatic enter_hunt();
        @(negedge clk); hunt_cmd = 1'b1;
        @(negedge clk); hunt_cmd = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hunting", hunting, 1);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 overrun", overrun, 0);

        // Table: one vector per length code
        for (int k = 0; k < 4; k++) begin
            logic [30:0] v;
            int n;
            v = VEC[k];
            n = int'(v[30:26]);
            len_a = v[25]; len_b = v[24]; sync_pat = v[23:8];
            enter_hunt();
            for (int i = n - 1; i >= 1; i--) put_bit(v[8 + i]);
            chk("R4 no early sync", hunting, 1);
            put_bit(v[8]);
            chk("R2 R3 sync at N", hunting, 0);
            put_byte(v[7:0]);
            chk("R5 char ready", rd_valid, 1);
            chk("R5 R7 char value", rd_data, v[7:0]);
            pop();
            chk("R7 empty after pop", rd_valid, 0);
        end

        // Sliding hunt with leading stray bits, 8-bit pattern 0x7E
        len_a = 1'b1; len_b = 1'b0; sync_pat = 16'h007E;
        enter_hunt();
        begin
            logic [10:0] s;
            s = 11'b110_0111_1110;
            for (int i = 10; i >= 1; i--) put_bit(s[i]);
            chk("R4 slide no match", hunting, 1);
            put_bit(s[0]);
            chk("R4 slide match", hunting, 0);
        end

        // Strobe low: toggling data has no effect
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); rx_bit = i[0];
        end
        put_byte(8'h96);
        chk("R6 no shift w/o strobe", rd_data, 8'h96);
        pop();

        // Re-hunt: partial char discarded, fill restarted (stale bits end in 0)
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        enter_hunt();
        chk("R9 back to hunt", hunting, 1);
        begin
            logic [14:0] s;
            s = 15'b1111110_01111110;
            for (int i = 14; i >= 8; i--) put_bit(s[i]);
            chk("R9 stale bits no match", hunting, 1);
            for (int i = 7; i >= 0; i--) put_bit(s[i]);
            chk("R9 resync", hunting, 0);
        end
        put_byte(8'hC3);
        chk("R9 fresh char", rd_data, 8'hC3);
        pop();
        chk("R7 empty", rd_valid, 0);

        // Overflow: five characters into four slots
        put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); put_byte(8'h44);
        chk("R8 no overrun at full", overrun, 0);
        put_byte(8'h55);
        chk("R8 overrun set", overrun, 1);
        for (int i = 1; i <= 4; i++) begin
            chk("R7 R8 fifo order", rd_data, 32'(8'h11 * i));
            pop();
        end
        chk("R8 dropped byte absent", rd_valid, 0);
        chk("R8 overrun sticky", overrun, 1);

        // Reset clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 overrun cleared", overrun, 0);
        chk("R1 hunting after reset", hunting, 1);

        summary();
    end
endmodule